// File: doc/BRIEF.md
# Board Control Register Block

This block is a small memory-mapped peripheral that answers on a simple synchronous register bus. The bus carries an address, a write strobe with write data, and a read strobe; read data returns registered on the next cycle. Inside a 64 KiB window the block offers two constant words: an identification value and the board's reference-clock frequency in hertz. It also holds a read/write register that drives the LED pins and a read-only register that mirrors the board's switch pins.

The switch pins are asynchronous to the bus clock. They cross into the clock domain through a two-flop synchroniser and are then captured into the switch register.

One word in the window acts as a reset trigger. Writing one exact 32-bit key to it makes the block raise a one-cycle system reset request toward an external reset controller. Any other value written there changes nothing. Every offset that is not decoded reads as zero and ignores writes.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset, led_out is zero, sys_rst_req is low, bus_rdata is zero, and a read of the switch word (offset 0xC) returns zero until the synchronised inputs arrive.
- R2: A read strobe at byte offset 0x0 makes bus_rdata equal 0x09272011 on the following cycle.
- R3: A read strobe at byte offset 0x4 makes bus_rdata equal 10000000 (decimal) on the following cycle.
- R4: A write at offset 0x8 stores all 32 data bits. led_out shows the new value from the cycle after the write, and reads at 0x8 return it. A read in the same cycle as a write returns the old value.
- R5: A read at offset 0xC returns sw_in zero-extended to 32 bits. sw_in reaches the register three clock edges after it is applied: two synchroniser stages, then the capture register.
- R6: Writes at any offset other than 0x8 and 0x10 change neither led_out nor any readable value. This includes offsets 0x0, 0x4 and 0xC.
- R7: A write of exactly 0x0000DEAD at offset 0x10 drives sys_rst_req high on the next cycle, for that one cycle only. The request rises again only on a further such write.
- R8: A write at offset 0x10 with any other 32-bit value, for example 0xDEAE or 0x1DEAD, produces no request and leaves led_out unchanged.
- R9: Reads at offset 0x10 and at every offset not decoded return zero. Offset 0xFFFC, the last word of the window, is one such offset.
- R10: In a cycle that does not follow a read strobe, bus_rdata is zero.
- R11: Offsets are decoded only when word-aligned. A misaligned access such as offset 0x9 or 0x11 reads zero, and a write there has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data, valid the cycle after bus_rd |
| sw_in | input | SW_W (8) | Asynchronous switch pins |
| led_out | output | DATA_W (32) | LED register contents |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is the trigger word receiving a value that differs from the key only in bits the key leaves clear. Examples are 0x1DEAD and 0xDEAD written one byte off at 0x11. These must produce no request.

The stimulus writes these near-miss values between genuine key writes, including two key writes back to back. A reference model compares every cycle, so a pulse one cycle late or an extra pulse shows up. Switch changes are applied while reads of offset 0xC run on every cycle, which exposes the exact three-edge latency.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;
  // Byte offsets of the decoded words (behavioural map)
  localparam logic [31:0] OFS_IDENT = 32'h0000_0000;
  localparam logic [31:0] OFS_FREQ  = 32'h0000_0004;
  localparam logic [31:0] OFS_LED   = 32'h0000_0008;
  localparam logic [31:0] OFS_SWITCH = 32'h0000_000C;
  localparam logic [31:0] OFS_TRIG  = 32'h0000_0010;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IDENT,
    SEL_FREQ,
    SEL_LED,
    SEL_SWITCH,
    SEL_TRIG
  } word_sel_e;
endpackage

// File: rtl/bc_switch_sync.sv
module bc_switch_sync #(
  parameter int SW_W   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW_W-1:0] pins,
  output logic [SW_W-1:0] sw_q
);
  logic [SW_W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= pins;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  // Capture register seen by the bus
  always_ff @(posedge clk) begin
    if (rst) sw_q <= '0;
    else     sw_q <= chain[STAGES-1];
  end
endmodule

// File: rtl/bc_regfile.sv
module bc_regfile
  import board_ctrl_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          SW_W   = 8,
  parameter logic [31:0] IDENT  = 32'h0927_2011,
  parameter logic [31:0] CLK_HZ = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  word_sel_e         sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic [SW_W-1:0]   sw_q,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] led
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst)                      led <= '0;
    else if (wr && sel == SEL_LED) led <= wdata;
  end

  always_comb begin
    case (sel)
      SEL_IDENT:  rd_mux = DATA_W'(IDENT);
      SEL_FREQ:   rd_mux = DATA_W'(CLK_HZ);
      SEL_LED:    rd_mux = led;
      SEL_SWITCH: rd_mux = DATA_W'(sw_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
    else         rdata <= '0;
  end

  // LED contents move only on a write to the LED word
  assert_led_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_LED) |=> $stable(led));

  // Idle cycles carry zero read data
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0);
endmodule

// File: rtl/bc_key_pulse.sv
module bc_key_pulse #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h0000_DEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              req
);
  logic key_ok;
  assign key_ok = trig_wr && (wdata == DATA_W'(KEY));

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= key_ok;
  end
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          SW_W        = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] IDENT       = 32'h0927_2011,
  parameter logic [31:0] CLK_HZ      = 32'd10_000_000,
  parameter logic [31:0] RESET_KEY   = 32'h0000_DEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SW_W-1:0]   sw_in,
  output logic [DATA_W-1:0] led_out,
  output logic              sys_rst_req
);
  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(OFS_IDENT);
  localparam logic [ADDR_W-1:0] A_FREQ   = ADDR_W'(OFS_FREQ);
  localparam logic [ADDR_W-1:0] A_LED    = ADDR_W'(OFS_LED);
  localparam logic [ADDR_W-1:0] A_SWITCH = ADDR_W'(OFS_SWITCH);
  localparam logic [ADDR_W-1:0] A_TRIG   = ADDR_W'(OFS_TRIG);

  word_sel_e       sel;
  logic [SW_W-1:0] sw_q;

  always_comb begin
    case (bus_addr)
      A_IDENT:  sel = SEL_IDENT;
      A_FREQ:   sel = SEL_FREQ;
      A_LED:    sel = SEL_LED;
      A_SWITCH: sel = SEL_SWITCH;
      A_TRIG:   sel = SEL_TRIG;
      default:  sel = SEL_NONE;
    endcase
  end

  bc_switch_sync #(.SW_W(SW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pins(sw_in), .sw_q(sw_q)
  );

  bc_regfile #(.DATA_W(DATA_W), .SW_W(SW_W), .IDENT(IDENT), .CLK_HZ(CLK_HZ)) u_regs (
    .clk(clk), .rst(rst), .sel(sel), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .sw_q(sw_q), .rdata(bus_rdata), .led(led_out)
  );

  bc_key_pulse #(.DATA_W(DATA_W), .KEY(RESET_KEY)) u_key (
    .clk(clk), .rst(rst), .trig_wr(bus_wr && sel == SEL_TRIG),
    .wdata(bus_wdata), .req(sys_rst_req)
  );

  // A request only follows a key write at the trigger offset
  assert_req_cause_R7: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(bus_wr && bus_addr == A_TRIG
                          && bus_wdata == DATA_W'(RESET_KEY)));

  // Identification word returned after a read of offset 0
  assert_ident_read_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == A_IDENT) |-> bus_rdata == DATA_W'(IDENT));

  // Trigger word reads as zero
  assert_trig_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == A_TRIG) |-> bus_rdata == '0);
endmodule

// File: tb/test_board_ctrl_regs.sv
module test_board_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  sw_in = '0;
  logic [31:0] led_out;
  logic        sys_rst_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  board_ctrl_regs i_board_ctrl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sw_in(sw_in), .led_out(led_out), .sys_rst_req(sys_rst_req)
  );

  // Behavioural reference model
  logic [31:0] m_led = '0;
  logic [7:0]  m_swq [$];
  logic [31:0] m_rdata = '0;
  logic        m_req = 1'b0;
  string       m_tag = "R1";
  string       m_led_tag = "R1";
  string       m_req_tag = "R1";

  function automatic logic [7:0] sw_visible();
    return m_swq[0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_led = '0; m_rdata = '0; m_req = 1'b0; m_tag = "R1";
      m_swq = '{8'h0, 8'h0, 8'h0};
    end else begin
      logic [31:0] nrd;
      nrd = 0;
      m_tag = "R10";
      if (bus_rd) begin
        case (bus_addr)
          16'h0000: begin nrd = 32'h0927_2011; m_tag = "R2"; end
          16'h0004: begin nrd = 32'd10000000; m_tag = "R3"; end
          16'h0008: begin nrd = m_led; m_tag = "R4"; end
          16'h000C: begin nrd = {24'h0, sw_visible()}; m_tag = "R5"; end
          default:  begin nrd = 0; m_tag = (bus_addr[1:0] != 0) ? "R11" : "R9"; end
        endcase
      end
      m_rdata = nrd;
      m_req_tag = (bus_wr && bus_addr == 16'h0010) ? "R8" : "R7";
      m_req = bus_wr && bus_addr == 16'h0010 && bus_wdata == 32'h0000_DEAD;
      if (m_req) m_req_tag = "R7";
      m_led_tag = (bus_wr && bus_addr != 16'h0008) ? "R6" : "R4";
      if (bus_wr && bus_addr == 16'h0008) m_led = bus_wdata;
      void'(m_swq.pop_front());
      m_swq.push_back(sw_in);
    end
  end

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare on every falling edge once out of reset
  always @(negedge clk) begin
    if (!rst && !done) begin
      check32(m_tag, "bus_rdata", bus_rdata, m_rdata);
      check32(m_led_tag, "led_out", led_out, m_led);
      check32(m_req_tag, "sys_rst_req", {31'h0, sys_rst_req}, {31'h0, m_req});
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
  endtask

  task automatic rd(logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check32("R1", "reset led_out", led_out, 32'h0);
    check32("R1", "reset rdata", bus_rdata, 32'h0);
    check32("R1", "reset req", {31'h0, sys_rst_req}, 32'h0);
    @(negedge clk); rst = 1'b0;
    rd(16'h000C); // R1 switch reads zero
    rd(16'h0000); rd(16'h0004); idle(2);
    // R4 LED path, including write then read back and simultaneous
    wr(16'h0008, 32'hA5A5_0F0F); rd(16'h0008);
    @(negedge clk); bus_addr = 16'h0008; bus_wdata = 32'h1234_5678;
    bus_wr = 1'b1; bus_rd = 1'b1; // same-cycle read returns old
    rd(16'h0008); idle(1);
    // R6 writes to other offsets ignored
    wr(16'h0000, 32'hFFFF_FFFF); wr(16'h0004, 32'h0); wr(16'h000C, 32'hFF);
    wr(16'h0020, 32'hDEAD); wr(16'hFFFC, 32'h1);
    rd(16'h0000); rd(16'h0004); rd(16'h000C); rd(16'h0008); idle(1);
    // R5 switch latency, read every cycle
    @(negedge clk); sw_in = 8'h5A;
    for (int i = 0; i < 6; i++) rd(16'h000C);
    @(negedge clk); sw_in = 8'hC3;
    for (int i = 0; i < 6; i++) rd(16'h000C);
    sw_in = 8'hFF; for (int i = 0; i < 5; i++) rd(16'h000C);
    // R7 key writes, single and back to back
    idle(1); wr(16'h0010, 32'h0000_DEAD); idle(3);
    wr(16'h0010, 32'h0000_DEAD); wr(16'h0010, 32'h0000_DEAD); idle(2);
    // R8 near-miss values
    wr(16'h0010, 32'h0000_DEAE); wr(16'h0010, 32'h0001_DEAD);
    wr(16'h0010, 32'hDEAD_0000); wr(16'h0010, 32'h0);
    // R11 misaligned key write and LED write
    wr(16'h0011, 32'h0000_DEAD); wr(16'h0009, 32'h0BAD_F00D);
    rd(16'h0009); rd(16'h0011); rd(16'h0008); idle(2);
    // R9 unmapped reads
    rd(16'h0010); rd(16'h0014); rd(16'hFFFC); rd(16'h8000);
    wr(16'h0008, 32'h0); rd(16'h0008); idle(3);
    finish_run();
  end
endmodule